// File: doc/BRIEF.md
# UART-to-SPI Flash Register Bridge

The bridge lets a host drive an SPI flash over an asynchronous serial line. The host sends register numbers and data bytes. The bridge decodes them into accesses to three internal registers, and those registers steer a byte-wide SPI master. The host builds every flash command sequence itself: it asserts chip select, streams command, address and data bytes, and then releases chip select.

A single write to the SPI data register does two things. It sends the written byte to the flash, and it captures the byte the flash returns during the same eight clocks. To read flash data, the host therefore writes a dummy byte and then reads the captured byte back. That costs four serial bytes per flash byte.

After reset the bridge stays silent until the host sends a greeting byte. The bridge answers it once and then serves that one session until the next reset.

Top module: `uart_spi_bridge`

## Requirements
- R1: Serial frames are 8N1, least significant bit first, with CLK_HZ/BAUD system clocks per bit. The transmit line idles high whenever no reply is being sent.
- R2: After reset, every received byte other than 0x5A is discarded, with no reply and no effect on any register. The byte 0x5A is answered with 0xA5 and opens the session.
- R3: Only one session opens per reset. Once the session is open, 0x5A is handled as an ordinary write command to register 0x5A, and no 0xA5 reply is sent. A reset re-arms the greeting.
- R4: Within a session, a command byte with bit 7 set is a read of the register in bits 6:0, and the bridge returns exactly one byte. A command byte with bit 7 clear is a write, and the next received byte is its data.
- R5: Register 0x01 holds the chip-select enable in bit 0. When it is 1, cs_no is driven low. A read of register 0x01 returns {7'b0, enable}.
- R6: A write to register 0x00 produces exactly 8 rising SCLK edges in SPI mode 0. SCLK idles low, MOSI presents the written byte most significant bit first, and MOSI changes only after falling edges.
- R7: The byte sampled on MISO at the 8 rising edges, first bit as the MSB, is captured. A read of register 0x00 returns it until the next transfer.
- R8: A byte that arrives while a transfer is running is held, and it is acted on only after the transfer ends. A read placed directly behind a data write therefore returns the freshly captured byte. Back-to-back streams of data writes lose no byte.
- R9: cs_no changes only through writes to register 0x01. It stays unchanged across a stream of data writes.
- R10: Register 0x02 reads {7'b0, busy} and ignores writes. Reads of unmapped registers return 0x00. Writes to unmapped registers have no effect.
- R11: Each SCLK phase, high and low, lasts SPI_HALF system clocks. Consecutive rising edges within a byte are therefore 2*SPI_HALF clocks apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 1 | Serial data from the host |
| txd_o | output | 1 | Serial data to the host |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | SPI data to the flash |
| miso_i | input | 1 | SPI data from the flash |
| cs_no | output | 1 | Active-low flash chip select |

## Verification
The bench sweeps all 256 data values through a write followed at once by a read, so every read lands while the transfer is still running. A bridge that did not hold bytes would return the previous capture or a busy status, and a bridge that shifted LSB first or sampled on the wrong edge would return a bit-reversed or shifted byte. A second greeting after the session opens, and greetings or writes sent before it, would produce a spurious 0xA5 or a chip-select change in a bridge that does not lock or does not discard. A back-to-back stream of data writes shows dropped bytes or a chip-select glitch as a wrong or missing MOSI byte.

// File: rtl/uart_spi_bridge_pkg.sv
package uart_spi_bridge_pkg;
  typedef enum logic [1:0] {ST_HUNT, ST_CMD, ST_WDATA} brg_state_e;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rx_phase_e;

  localparam logic [7:0] HELLO_BYTE = 8'h5A;
  localparam logic [7:0] ACK_BYTE   = 8'hA5;
  localparam logic [6:0] REG_DATA   = 7'h00;
  localparam logic [6:0] REG_CSEL   = 7'h01;
  localparam logic [6:0] REG_STAT   = 7'h02;
endpackage

// File: rtl/brg_uart_rx.sv
module brg_uart_rx
  import uart_spi_bridge_pkg::*;
#(
  parameter int CLKS_PER_BIT = 434
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rxd_i,
  output logic       valid_o,
  output logic [7:0] data_o
);
  localparam int CW   = $clog2(CLKS_PER_BIT + 1);
  localparam int HALF = CLKS_PER_BIT / 2;

  logic            rx_s1, rx_s2;
  rx_phase_e       ph;
  logic [CW-1:0]   cnt;
  logic [2:0]      bit_idx;
  logic [7:0]      sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_s1   <= 1'b1;
      rx_s2   <= 1'b1;
      ph      <= RX_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      sh      <= '0;
      valid_o <= 1'b0;
    end else begin
      rx_s1   <= rxd_i;
      rx_s2   <= rx_s1;
      valid_o <= 1'b0;
      unique case (ph)
        RX_IDLE: if (!rx_s2) begin
          ph  <= RX_START;
          cnt <= '0;
        end
        RX_START: if (cnt == CW'(HALF - 1)) begin
          cnt     <= '0;
          bit_idx <= '0;
          ph      <= rx_s2 ? RX_IDLE : RX_BITS;
        end else cnt <= cnt + 1'b1;
        RX_BITS: if (cnt == CW'(CLKS_PER_BIT - 1)) begin
          cnt <= '0;
          sh  <= {rx_s2, sh[7:1]};
          if (bit_idx == 3'd7) ph <= RX_STOP;
          else bit_idx <= bit_idx + 1'b1;
        end else cnt <= cnt + 1'b1;
        RX_STOP: if (cnt == CW'(CLKS_PER_BIT - 1)) begin
          cnt     <= '0;
          ph      <= RX_IDLE;
          valid_o <= rx_s2;  // framing error drops the byte
        end else cnt <= cnt + 1'b1;
        default: ph <= RX_IDLE;
      endcase
    end
  end

  assign data_o = sh;
endmodule

// File: rtl/brg_uart_tx.sv
module brg_uart_tx #(
  parameter int CLKS_PER_BIT = 434
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] data_i,
  output logic       busy_o,
  output logic       txd_o
);
  localparam int CW = $clog2(CLKS_PER_BIT + 1);

  logic [CW-1:0] cnt;
  logic [8:0]    frame_q;
  logic [3:0]    left;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      txd_o   <= 1'b1;
      cnt     <= '0;
      frame_q <= '1;
      left    <= '0;
    end else if (!busy_o) begin
      if (start_i) begin
        busy_o  <= 1'b1;
        txd_o   <= 1'b0;
        frame_q <= {1'b1, data_i};
        left    <= 4'd9;
        cnt     <= '0;
      end
    end else if (cnt == CW'(CLKS_PER_BIT - 1)) begin
      cnt <= '0;
      if (left == 4'd0) begin
        busy_o <= 1'b0;
        txd_o  <= 1'b1;
      end else begin
        txd_o   <= frame_q[0];
        frame_q <= {1'b1, frame_q[8:1]};
        left    <= left - 1'b1;
      end
    end else cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/brg_spi_master.sv
module brg_spi_master #(
  parameter int HALF_CLKS = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] data_i,
  input  logic       miso_i,
  output logic       busy_o,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic [7:0] rx_o
);
  localparam int CW = $clog2(HALF_CLKS + 1);

  logic [CW-1:0] div;
  logic [3:0]    rises;
  logic [7:0]    tx_sh, rx_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      sclk_o <= 1'b0;
      div    <= '0;
      rises  <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      rx_o   <= '0;
    end else if (!busy_o) begin
      if (start_i) begin
        busy_o <= 1'b1;
        tx_sh  <= data_i;
        div    <= '0;
        rises  <= '0;
      end
    end else if (div == CW'(HALF_CLKS - 1)) begin
      div <= '0;
      if (!sclk_o) begin
        sclk_o <= 1'b1;
        rx_sh  <= {rx_sh[6:0], miso_i};
        rises  <= rises + 1'b1;
      end else begin
        sclk_o <= 1'b0;
        if (rises == 4'd8) begin
          busy_o <= 1'b0;
          rx_o   <= rx_sh;
        end else tx_sh <= {tx_sh[6:0], 1'b0};
      end
    end else div <= div + 1'b1;
  end

  assign mosi_o = tx_sh[7];
endmodule

// File: rtl/uart_spi_bridge.sv
module uart_spi_bridge
  import uart_spi_bridge_pkg::*;
#(
  parameter int CLK_HZ   = 50_000_000,
  parameter int BAUD     = 115_200,
  parameter int SPI_HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rxd_i,
  output logic txd_o,
  output logic sclk_o,
  output logic mosi_o,
  input  logic miso_i,
  output logic cs_no
);
  localparam int CLKS_PER_BIT = CLK_HZ / BAUD;

  logic       rx_valid;
  logic [7:0] rx_data;
  logic       tx_start, tx_busy;
  logic [7:0] tx_data;
  logic       spi_start, spi_busy;
  logic [7:0] spi_rx;

  brg_state_e state;
  logic       pend_v;
  logic [7:0] pend_q;
  logic [6:0] wr_addr;
  logic       cs_en;
  logic       go;
  logic [7:0] rd_val;
  logic       session_open;

  brg_uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) i_rx (
    .clk_i, .rst_ni, .rxd_i, .valid_o(rx_valid), .data_o(rx_data)
  );

  brg_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) i_tx (
    .clk_i, .rst_ni, .start_i(tx_start), .data_i(tx_data),
    .busy_o(tx_busy), .txd_o
  );

  brg_spi_master #(.HALF_CLKS(SPI_HALF)) i_spi (
    .clk_i, .rst_ni, .start_i(spi_start), .data_i(pend_q), .miso_i,
    .busy_o(spi_busy), .sclk_o, .mosi_o, .rx_o(spi_rx)
  );

  // held byte waits for both the shifter and the reply path
  assign go           = pend_v && !spi_busy && !tx_busy;
  assign session_open = (state != ST_HUNT);
  assign cs_no        = ~cs_en;

  always_comb begin
    unique case (pend_q[6:0])
      REG_DATA: rd_val = spi_rx;
      REG_CSEL: rd_val = {7'b0, cs_en};
      REG_STAT: rd_val = {7'b0, spi_busy};
      default:  rd_val = 8'h00;
    endcase
  end

  always_comb begin
    tx_start  = 1'b0;
    tx_data   = ACK_BYTE;
    spi_start = 1'b0;
    if (go) begin
      unique case (state)
        ST_HUNT:  tx_start = (pend_q == HELLO_BYTE);
        ST_CMD: if (pend_q[7]) begin
          tx_start = 1'b1;
          tx_data  = rd_val;
        end
        ST_WDATA: spi_start = (wr_addr == REG_DATA);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_HUNT;
      pend_v  <= 1'b0;
      pend_q  <= '0;
      wr_addr <= '0;
      cs_en   <= 1'b0;
    end else begin
      if (go) pend_v <= 1'b0;
      if (rx_valid) begin
        pend_v <= 1'b1;
        pend_q <= rx_data;
      end
      if (go) begin
        unique case (state)
          ST_HUNT: if (pend_q == HELLO_BYTE) state <= ST_CMD;
          ST_CMD: if (!pend_q[7]) begin
            wr_addr <= pend_q[6:0];
            state   <= ST_WDATA;
          end
          ST_WDATA: begin
            state <= ST_CMD;
            if (wr_addr == REG_CSEL) cs_en <= pend_q[0];
          end
          default: state <= ST_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_spi_bridge_chk.sv
module uart_spi_bridge_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic txd_o,
  input logic sclk_o,
  input logic cs_no,
  input logic spi_busy_i,
  input logic tx_busy_i,
  input logic rx_valid_i,
  input logic pend_v_i,
  input logic session_i
);
  logic       sclk_d;
  logic [3:0] rise_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d   <= 1'b0;
      rise_cnt <= '0;
    end else begin
      sclk_d <= sclk_o;
      if (!spi_busy_i) rise_cnt <= '0;
      else if (sclk_o && !sclk_d) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  AST_TXD_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy_i |-> txd_o);  // R1
  AST_SILENT_BEFORE_HELLO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !txd_o |-> session_i);  // R2
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spi_busy_i |-> !sclk_o);  // R6
  AST_EIGHT_EDGES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(spi_busy_i) |-> rise_cnt == 4'd8);  // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |-> !pend_v_i);  // R8
  AST_CS_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spi_busy_i && $past(spi_busy_i)) |-> $stable(cs_no));  // R9
endmodule

bind uart_spi_bridge uart_spi_bridge_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .txd_o      (txd_o),
  .sclk_o     (sclk_o),
  .cs_no      (cs_no),
  .spi_busy_i (spi_busy),
  .tx_busy_i  (tx_busy),
  .rx_valid_i (rx_valid),
  .pend_v_i   (pend_v),
  .session_i  (session_open)
);

// File: tb/test_uart_spi_bridge.sv
`timescale 1ns/1ps
module test_uart_spi_bridge;
  localparam int CLK_HZ   = 1_600_000;
  localparam int BAUD     = 200_000;
  localparam int BIT      = CLK_HZ / BAUD;
  localparam int SPI_HALF = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rxd = 1'b1;
  logic txd, sclk, mosi, miso, cs_n;

  int n_checks = 0, n_err = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_spi_bridge #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .SPI_HALF(SPI_HALF)) i_uart_spi_bridge (
    .clk_i(clk), .rst_ni(rst_ni), .rxd_i(rxd), .txd_o(txd),
    .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .cs_no(cs_n)
  );

  function automatic logic [7:0] resp_of(input int n);
    return 8'((n * 29) + 60) ^ 8'h96;
  endfunction

  // flash model: mode 0, MSB first, one response byte per transfer
  int         rises = 0;
  int         last_rise = 0;
  int         cs_bad = 0, per_bad = 0;
  logic [7:0] mon_sh = '0;
  logic [7:0] mosi_log [64];
  logic [7:0] cur_resp;

  assign cur_resp = resp_of(rises / 8);
  assign miso     = cur_resp[7 - (rises % 8)];

  always @(posedge sclk) begin
    if (cs_n) cs_bad++;
    if ((rises % 8) != 0 && (cyc - last_rise) != 2 * SPI_HALF) per_bad++;
    last_rise = cyc;
    mon_sh = {mon_sh[6:0], mosi};
    rises++;
    if (rises % 8 == 0) mosi_log[(rises / 8 - 1) % 64] = mon_sh;
  end

  // host-side receiver
  int         rx_n = 0;
  logic [7:0] rx_got = '0;
  always begin
    logic [7:0] v;
    @(negedge txd);
    repeat (BIT / 2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      repeat (BIT) @(negedge clk);
      v[i] = txd;
    end
    repeat (BIT) @(negedge clk);
    rx_got = v;
    rx_n++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk) rxd = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (BIT) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] cmd, output logic [7:0] v, output bit got);
    int n0 = rx_n;
    send(cmd);
    got = 1'b0;
    for (int i = 0; i < 60 * BIT; i++) begin
      @(negedge clk);
      if (rx_n != n0) begin
        got = 1'b1;
        break;
      end
    end
    v = rx_got;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] cmd, input logic [7:0] exp);
    logic [7:0] v;
    bit got;
    rd(cmd, v, got);
    chk({req, " reply present"}, int'(got), 1);
    chk(req, int'(v), int'(exp));
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    repeat (190_000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    int n0, r0;
    repeat (5) @(negedge clk);
    // R1 R5 R6 reset state
    chk("R1 txd idle", int'(txd), 1);
    chk("R5 cs released", int'(cs_n), 1);
    chk("R6 sclk idle", int'(sclk), 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);

    // R2 bytes before greeting are dropped
    send(8'h01); send(8'h01); send(8'h80); send(8'h00); send(8'h33);
    repeat (20 * BIT) @(negedge clk);
    chk("R2 no reply before greeting", rx_n, 0);
    chk("R2 cs untouched before greeting", int'(cs_n), 1);
    chk("R2 no spi before greeting", rises, 0);
    rd_chk("R2 greeting ack", 8'h5A, 8'hA5);

    // R3 a second greeting is a plain write to reg 0x5A
    n0 = rx_n;
    send(8'h5A);
    repeat (30 * BIT) @(negedge clk);
    chk("R3 no second ack", rx_n, n0);
    send(8'h01);
    repeat (4 * BIT) @(negedge clk);
    chk("R3 second greeting data ignored", int'(cs_n), 1);
    chk("R3 no spi from second greeting", rises, 0);

    // R4 R5 chip select register
    send(8'h01); send(8'h01);
    repeat (4) @(negedge clk);
    chk("R5 cs asserted", int'(cs_n), 0);
    rd_chk("R4 R5 csel readback", 8'h81, 8'h01);

    // R10 unmapped and read-only registers
    rd_chk("R10 unmapped read", 8'h85, 8'h00);
    send(8'h05); send(8'hFE);
    send(8'h02); send(8'hFF);
    rd_chk("R10 csel after unmapped write", 8'h81, 8'h01);
    rd_chk("R10 status idle after write", 8'h82, 8'h00);
    chk("R10 no spi from other writes", rises, 0);

    // R8 R10 status read held behind a transfer
    send(8'h00); send(8'hC4);
    rd_chk("R8 status held until idle", 8'h82, 8'h00);
    chk("R6 eight edges first byte", rises, 8);
    chk("R6 first mosi byte", int'(mosi_log[0]), 8'hC4);
    rd_chk("R7 first capture", 8'h80, resp_of(0));

    // R6 R7 R8 exhaustive data sweep, read placed right behind each write
    for (int v = 0; v < 256; v++) begin
      r0 = rises;
      send(8'h00); send(8'(v));
      rd_chk("R7 R8 capture after write", 8'h80, resp_of(r0 / 8));
      chk("R6 edges per write", rises - r0, 8);
      chk("R6 mosi byte", int'(mosi_log[(r0 / 8) % 64]), v);
    end

    // R8 R9 back-to-back stream
    r0 = rises;
    for (int k = 0; k < 12; k++) begin
      send(8'h00); send(8'(k * 19 + 7));
    end
    repeat (40 * SPI_HALF) @(negedge clk);
    chk("R8 stream no loss", rises - r0, 96);
    for (int k = 0; k < 12; k++)
      chk("R8 stream order", int'(mosi_log[(r0 / 8 + k) % 64]), (k * 19 + 7) % 256);
    chk("R9 cs held across stream", int'(cs_n), 0);
    rd_chk("R7 capture after stream", 8'h80, resp_of(r0 / 8 + 11));
    chk("R9 cs low on every edge", cs_bad, 0);
    chk("R11 sclk period", per_bad, 0);
    chk("R6 sclk idle between", int'(sclk), 0);

    // R5 release
    send(8'h01); send(8'h00);
    repeat (4) @(negedge clk);
    chk("R5 cs released by write", int'(cs_n), 1);
    rd_chk("R5 csel reads zero", 8'h81, 8'h00);
    chk("R1 txd idle after replies", int'(txd), 1);

    // R3 reset re-arms greeting
    rst_ni = 1'b0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    rd_chk("R3 greeting after reset", 8'h5A, 8'hA5);
    rd_chk("R7 capture cleared by reset", 8'h80, 8'h00);

    summary();
  end
endmodule